// File: doc/BRIEF.md
# E1 Transmit Clock Guard

This block sits ahead of an E1 line driver and decides what the driver sends based on the health of the incoming transmit clock. It runs on a fast free-running reference clock, at least sixteen times the 2.048 MHz line rate. The transmit clock and both data rails pass through a synchronizer on that reference clock. While the transmit clock toggles, the block captures the positive and negative data rails on a selectable edge and forwards them as line-drive enables.

When the transmit clock holds one level for longer than a programmable count of reference cycles, set to match 10 µs, the block classifies the fault. A clock stuck high switches the output to a continuous all-ones AMI pattern, timed from the reference clock. A clock stuck low powers the transmitter down, and the output-enable flag goes low so the line is tri-stated. Normal operation returns after a run of consecutive clock edges.

A manual off input overrides everything else and disables the outputs. All outputs are registered.

Top module: `e1_txclk_guard`

## Requirements
- R1: While `rst` is high and after it is released, `drv_oe`, `drv_pos` and `drv_neg` are 0 until transmit clock activity is qualified (R5).
- R2: If the synchronized transmit clock stays high for more than `STUCK_CYCLES` reference cycles, the block enters all-ones AMI mode with `drv_oe` = 1, and the first mark appears on `drv_pos`.
- R3: In all-ones AMI mode, each bit period lasts `BIT_CYCLES` reference cycles. A mark is driven for the first `BIT_CYCLES/2` cycles of each period, and the marks alternate strictly: positive, negative, positive, and so on.
- R4: If the synchronized transmit clock stays low for more than `STUCK_CYCLES` reference cycles, the block powers down: `drv_oe` = 0 and both drive outputs are 0.
- R5: From power-down or AMI mode, data mode resumes after `RESUME_EDGES` (4) consecutive transmit clock edges, counting both rising and falling edges. Fewer edges leave the mode unchanged. A stuck timeout clears the edge count.
- R6: `edge_sel` = 1 captures the rails on the rising transmit clock edge, and `edge_sel` = 0 on the falling edge. The captured value is held until the next capture edge.
- R7: In data mode, `drv_oe` = 1, and a captured positive-rail-only bit sets `drv_pos`, a negative-rail-only bit sets `drv_neg`, and a bit with neither rail high sets neither.
- R8: A captured bit with both rails high drives both outputs low. `drv_pos` and `drv_neg` are never 1 in the same cycle.
- R9: While `tx_off` is high, `drv_oe`, `drv_pos` and `drv_neg` are 0 from the next reference cycle, in every mode.
- R10: A stuck level is not acted on before `STUCK_CYCLES` reference cycles have elapsed, so outputs keep their previous data-mode values until then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Free-running reference clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_clk | input | 1 | Transmit clock, asynchronous to ref_clk |
| pos_in | input | 1 | Positive-polarity data rail |
| neg_in | input | 1 | Negative-polarity data rail |
| edge_sel | input | 1 | Capture edge: 1 rising, 0 falling |
| tx_off | input | 1 | Manual transmitter off, forces outputs disabled |
| drv_pos | output | 1 | Positive line-drive enable |
| drv_neg | output | 1 | Negative line-drive enable |
| drv_oe | output | 1 | Output enable; 0 means tri-state |

## Verification
The assertions assume that `rst` is asserted at the first reference edge, and that `tx_off` and `edge_sel` are levels sampled on the reference clock. The assertions make no assumption about the data rails, so the one-hot property on the drive outputs must hold for any rail pattern, including both rails high. The stimulus drives all inputs on the falling reference edge. It keeps the data rails steady for a full transmit half-period around each capture edge, so that the synchronizer never sees a rail change in the same cycle as the clock edge that captures it.

// File: rtl/e1g_pkg.sv
package e1g_pkg;
  typedef enum logic [1:0] {
    MODE_DOWN = 2'd0,
    MODE_DATA = 2'd1,
    MODE_AIS  = 2'd2
  } e1g_mode_t;
endpackage

// File: rtl/e1g_edge_sync.sv
module e1g_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic tx_clk,
  input  logic pos_in,
  input  logic neg_in,
  output logic lvl,
  output logic rise,
  output logic fall,
  output logic pos_s,
  output logic neg_s
);
  logic [STAGES-1:0] clk_sh;
  logic [STAGES-1:0] pos_sh;
  logic [STAGES-1:0] neg_sh;
  logic              prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      clk_sh <= '0;
      pos_sh <= '0;
      neg_sh <= '0;
      prev   <= 1'b0;
    end else begin
      clk_sh <= {clk_sh[STAGES-2:0], tx_clk};
      pos_sh <= {pos_sh[STAGES-2:0], pos_in};
      neg_sh <= {neg_sh[STAGES-2:0], neg_in};
      prev   <= clk_sh[STAGES-1];
    end
  end

  assign lvl   = clk_sh[STAGES-1];
  assign rise  = lvl & ~prev;
  assign fall  = ~lvl & prev;
  assign pos_s = pos_sh[STAGES-1];
  assign neg_s = neg_sh[STAGES-1];
endmodule

// File: rtl/e1g_activity.sv
module e1g_activity
  import e1g_pkg::*;
#(
  parameter int STUCK_CYCLES = 2000,
  parameter int RESUME_EDGES = 4
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      lvl,
  input  logic      any_edge,
  output e1g_mode_t mode
);
  localparam int CW = $clog2(STUCK_CYCLES + 1);
  localparam int EW = $clog2(RESUME_EDGES + 1);

  logic [CW-1:0] run_cnt;
  logic [EW-1:0] edge_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode     <= MODE_DOWN;
      run_cnt  <= '0;
      edge_cnt <= '0;
    end else if (any_edge) begin
      run_cnt <= '0;
      if (mode != MODE_DATA) begin
        if (edge_cnt == EW'(RESUME_EDGES - 1)) begin
          mode     <= MODE_DATA;
          edge_cnt <= '0;
        end else begin
          edge_cnt <= edge_cnt + 1'b1;
        end
      end
    end else if (run_cnt == CW'(STUCK_CYCLES)) begin
      mode     <= lvl ? MODE_AIS : MODE_DOWN;
      edge_cnt <= '0;
    end else begin
      run_cnt <= run_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/e1g_ais_gen.sv
module e1g_ais_gen #(
  parameter int BIT_CYCLES = 98
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic ais_pos,
  output logic ais_neg
);
  localparam int BW   = $clog2(BIT_CYCLES);
  localparam int HALF = BIT_CYCLES / 2;

  logic [BW-1:0] cnt;
  logic          phase;
  logic          mark;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt   <= '0;
      phase <= 1'b0;
    end else if (cnt == BW'(BIT_CYCLES - 1)) begin
      cnt   <= '0;
      phase <= ~phase;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign mark    = en && (cnt < BW'(HALF));
  assign ais_pos = mark && !phase;
  assign ais_neg = mark && phase;
endmodule

// File: rtl/e1_txclk_guard.sv
module e1_txclk_guard
  import e1g_pkg::*;
#(
  parameter int SYNC_STAGES  = 2,
  parameter int STUCK_CYCLES = 2000,
  parameter int BIT_CYCLES   = 98,
  parameter int RESUME_EDGES = 4
) (
  input  logic ref_clk,
  input  logic rst,
  input  logic tx_clk,
  input  logic pos_in,
  input  logic neg_in,
  input  logic edge_sel,
  input  logic tx_off,
  output logic drv_pos,
  output logic drv_neg,
  output logic drv_oe
);
  logic      lvl, rise, fall, pos_s, neg_s;
  logic      ais_pos, ais_neg;
  logic      samp_pos, samp_neg;
  e1g_mode_t mode;

  e1g_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(ref_clk), .rst(rst), .tx_clk(tx_clk), .pos_in(pos_in), .neg_in(neg_in),
    .lvl(lvl), .rise(rise), .fall(fall), .pos_s(pos_s), .neg_s(neg_s)
  );

  e1g_activity #(.STUCK_CYCLES(STUCK_CYCLES), .RESUME_EDGES(RESUME_EDGES)) u_act (
    .clk(ref_clk), .rst(rst), .lvl(lvl), .any_edge(rise | fall), .mode(mode)
  );

  e1g_ais_gen #(.BIT_CYCLES(BIT_CYCLES)) u_ais (
    .clk(ref_clk), .rst(rst), .en(mode == MODE_AIS),
    .ais_pos(ais_pos), .ais_neg(ais_neg)
  );

  // capture both rails on the chosen edge; a doubled mark becomes a space
  always_ff @(posedge ref_clk) begin
    if (rst) begin
      samp_pos <= 1'b0;
      samp_neg <= 1'b0;
    end else if (edge_sel ? rise : fall) begin
      samp_pos <= pos_s & ~neg_s;
      samp_neg <= neg_s & ~pos_s;
    end
  end

  always_ff @(posedge ref_clk) begin
    if (rst || tx_off) begin
      drv_oe  <= 1'b0;
      drv_pos <= 1'b0;
      drv_neg <= 1'b0;
    end else begin
      case (mode)
        MODE_DATA: begin
          drv_oe  <= 1'b1;
          drv_pos <= samp_pos;
          drv_neg <= samp_neg;
        end
        MODE_AIS: begin
          drv_oe  <= 1'b1;
          drv_pos <= ais_pos;
          drv_neg <= ais_neg;
        end
        default: begin
          drv_oe  <= 1'b0;
          drv_pos <= 1'b0;
          drv_neg <= 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/e1g_guard_checks.sv
module e1g_guard_checks (
  input logic ref_clk,
  input logic rst,
  input logic tx_off,
  input logic drv_pos,
  input logic drv_neg,
  input logic drv_oe
);
  a_r8_never_both: assert property (@(posedge ref_clk) disable iff (rst)
    !(drv_pos && drv_neg));

  a_r9_off_forces_idle: assert property (@(posedge ref_clk) disable iff (rst)
    tx_off |=> (!drv_oe && !drv_pos && !drv_neg));

  a_r1_reset_idle: assert property (@(posedge ref_clk)
    rst |=> (!drv_oe && !drv_pos && !drv_neg));

  a_r4_quiet_when_disabled: assert property (@(posedge ref_clk) disable iff (rst)
    !drv_oe |-> (!drv_pos && !drv_neg));

  a_r3_mark_single_rail: assert property (@(posedge ref_clk) disable iff (rst)
    $countones({drv_pos, drv_neg}) <= 1);
endmodule

bind e1_txclk_guard e1g_guard_checks u_chk (
  .ref_clk(ref_clk), .rst(rst), .tx_off(tx_off),
  .drv_pos(drv_pos), .drv_neg(drv_neg), .drv_oe(drv_oe)
);

// File: tb/test_e1_txclk_guard.sv
`timescale 1ns/1ps
module test_e1_txclk_guard;
  localparam int STUCK = 40;
  localparam int BITC  = 6;
  localparam int HALF  = BITC / 2;

  logic ref_clk = 1'b0;
  logic rst = 1'b1;
  logic tx_clk = 1'b0, pos_in = 1'b0, neg_in = 1'b0, edge_sel = 1'b1, tx_off = 1'b0;
  logic drv_pos, drv_neg, drv_oe;
  int checks = 0;
  int fails = 0;

  always #2.5 ref_clk = ~ref_clk;

  e1_txclk_guard #(.SYNC_STAGES(2), .STUCK_CYCLES(STUCK), .BIT_CYCLES(BITC),
                   .RESUME_EDGES(4)) i_e1_txclk_guard (
    .ref_clk(ref_clk), .rst(rst), .tx_clk(tx_clk), .pos_in(pos_in), .neg_in(neg_in),
    .edge_sel(edge_sel), .tx_off(tx_off),
    .drv_pos(drv_pos), .drv_neg(drv_neg), .drv_oe(drv_oe)
  );

  task automatic chk(input string req, input logic eo, input logic ep, input logic en);
    checks++;
    if ({drv_oe, drv_pos, drv_neg} !== {eo, ep, en}) begin
      fails++;
      $display("FAIL %s: oe/pos/neg actual %b%b%b expected %b%b%b",
               req, drv_oe, drv_pos, drv_neg, eo, ep, en);
    end
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge ref_clk);
  endtask

  // one transmit bit: 8 reference cycles per half period
  task automatic send_bit(input logic p, input logic n, input bit do_chk, input string req);
    tx_clk = ~edge_sel;
    pos_in = p;
    neg_in = n;
    wait_n(8);
    tx_clk = edge_sel;
    wait_n(6);
    if (do_chk) chk(req, !tx_off, !tx_off && p && !n, !tx_off && n && !p);
    wait_n(2);
  endtask

  task automatic summary;
    $display("  %0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (150000) @(posedge ref_clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    summary();
    $finish;
  end

  initial begin
    wait_n(4);
    rst = 1'b0;
    wait_n(2);
    chk("R1 reset idle", 0, 0, 0);

    // warm up into data mode, rising-edge capture
    edge_sel = 1'b1;
    for (int i = 0; i < 3; i++) send_bit(0, 0, 0, "");

    // sweep capture edge and every rail combination
    for (int s = 1; s >= 0; s--) begin
      edge_sel = s[0];
      send_bit(0, 0, 0, "");
      send_bit(0, 0, 0, "");
      for (int c = 0; c < 4; c++) begin
        send_bit(c[1], c[0], 1, c == 3 ? "R8 both rails" :
                 (s == 1 ? "R6 rising capture R7" : "R6 falling capture R7"));
      end
      tx_off = 1'b1;
      send_bit(1, 0, 1, "R9 off in data mode");
      tx_off = 1'b0;
      send_bit(0, 1, 1, "R7 after off released");
    end

    // stuck high -> AMI all ones
    edge_sel = 1'b1;
    send_bit(0, 0, 1, "R7 idle bit");
    wait_n(STUCK - 5);
    chk("R10 no early AMI", 1, 0, 0);
    wait_n(2);
    chk("R2 first mark positive", 1, 1, 0);
    for (int k = 1; k < 4 * BITC; k++) begin
      @(negedge ref_clk);
      chk("R3 AMI pattern", 1,
          ((k / BITC) % 2 == 0) && (k % BITC < HALF),
          ((k / BITC) % 2 == 1) && (k % BITC < HALF));
    end
    tx_off = 1'b1;
    wait_n(2);
    chk("R9 off in AMI mode", 0, 0, 0);
    tx_off = 1'b0;

    // resume after four edges
    send_bit(1, 0, 0, "");
    send_bit(0, 1, 1, "R5 resume from AMI");

    // stuck low -> power down
    edge_sel = 1'b0;
    send_bit(0, 0, 1, "R6 falling idle bit");
    wait_n(STUCK - 5);
    chk("R10 no early power-down", 1, 0, 0);
    wait_n(2);
    chk("R4 power-down", 0, 0, 0);

    // three edges do not resume, fourth does
    tx_clk = 1'b1; wait_n(8);
    tx_clk = 1'b0; wait_n(8);
    tx_clk = 1'b1; wait_n(6);
    chk("R5 three edges stay down", 0, 0, 0);
    wait_n(2);
    tx_clk = 1'b0; wait_n(6);
    chk("R5 fourth edge resumes", 1, 0, 0);
    wait_n(2);
    send_bit(1, 0, 1, "R7 data after resume");

    summary();
    $finish;
  end
endmodule